// File: doc/BRIEF.md
# Byte-lane dual-port RAM

A clocked two-port static memory of 2048 sixteen-bit words. Two independent ports, A and B, can each read or write any word in any cycle. Each port has an active-low select, an active-low output enable and one active-low write strobe per byte. A single access can therefore write one byte and read back the other. Tri-state pins are replaced by a per-byte drive flag. A data byte whose flag is low reads as zero.

Each port also has an active-low hold input. While hold is low, every write on that port is suppressed, but its reads still complete. This allows an external arbiter to stall the losing port. The outputs are registered, and read data appears one cycle after the address is presented. A byte that the other port writes to the same word in the same cycle is passed straight through to the reading port, so the reader never sees stale data. If both ports write the same byte of the same word in one cycle, port A's data is stored.

Top module: `dpram_bytelane`

## Requirements
- R1: With `x_cs_n` high, port x writes nothing, and in the next cycle `x_drive` is 2'b00 and `x_rdata` is zero, whatever its other controls are.
- R2: With `x_cs_n` low, `x_hold_n` high and `x_we_n` = 2'b00, both bytes of `x_wdata` are stored at `x_addr`, and `x_drive` is 2'b00 in the next cycle.
- R3: With `x_cs_n` low, `x_oe_n` low and `x_we_n` = 2'b10 (bit 0 is the lower byte, bits 7:0; bit 1 is the upper byte, bits 15:8), the lower byte is written. In the next cycle `x_drive` is 2'b10 and `x_rdata[15:8]` holds the upper byte of the word.
- R4: With `x_we_n` = 2'b01 and the same select and enable, the upper byte is written. In the next cycle `x_drive` is 2'b01 and `x_rdata[7:0]` holds the lower byte.
- R5: With `x_cs_n` and `x_oe_n` low and `x_we_n` = 2'b11, the next cycle shows `x_drive` = 2'b11 and the whole word on `x_rdata`.
- R6: With `x_cs_n` low and `x_oe_n` high, `x_drive` is 2'b00 and `x_rdata` is zero in the next cycle.
- R7: While `x_hold_n` is low, port x stores nothing, and its reads of bytes whose strobe is high still return data.
- R8: Both ports may read the same word in the same cycle, and both return the same value.
- R9: A byte written by one port is returned, in the next cycle, by a read of the same word on the other port in that same cycle.
- R10: If both ports write the same byte of the same word in one cycle, port A's byte is kept.
- R11: During reset, and whenever a drive flag is low, the matching output byte is zero.
- R12: All 11 address bits select distinct words, so addresses 0x000 and 0x7FF do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| a_addr | input | 11 | Port A word address |
| a_cs_n | input | 1 | Port A select, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_we_n | input | 2 | Port A byte write strobes, active low (bit 0 lower byte) |
| a_hold_n | input | 1 | Port A write hold, active low blocks writes |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data, zero in undriven bytes |
| a_drive | output | 2 | Port A per-byte output drive flags |
| b_addr | input | 11 | Port B word address |
| b_cs_n | input | 1 | Port B select, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_we_n | input | 2 | Port B byte write strobes, active low (bit 0 lower byte) |
| b_hold_n | input | 1 | Port B write hold, active low blocks writes |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data, zero in undriven bytes |
| b_drive | output | 2 | Port B per-byte output drive flags |

## Verification
The bench targets mixed accesses that write one byte and read the other. A design that mixes up the lanes would drive the wrong flag or corrupt the byte being read. Held writes are issued both alone and alongside a read of the other byte. A design that ignored hold would show the blocked data on a later read, and one that also blocked reads would drop the flag.

Same-cycle cross-port traffic is covered in three forms: a full-word write against a read, two half-word writes that each read the other's byte, and a write collision. A design without forwarding would return the old word, and one with the wrong priority would keep port B's byte. Deselected strobes, the lowest and highest addresses, and a reset asserted mid-read close the set.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    // Two byte lanes per word: index 0 is the lower byte, 1 the upper byte.
    localparam int unsigned NLANES = 2;

    typedef enum logic [1:0] {
        LANE_IDLE  = 2'd0,
        LANE_WRITE = 2'd1,
        LANE_READ  = 2'd2
    } lane_op_e;
endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode
    import dpr_pkg::*;
#(
    parameter int unsigned LANES = NLANES
) (
    input  logic             cs_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] we_n,
    input  logic             hold_n,
    output logic [LANES-1:0] wr_en,
    output logic [LANES-1:0] rd_en
);
    lane_op_e lane_op [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            lane_op[i] = LANE_IDLE;
            if (!cs_n) begin
                if (!we_n[i]) begin
                    // A strobed lane takes data in; the hold input only gates storage.
                    lane_op[i] = hold_n ? LANE_WRITE : LANE_IDLE;
                end else if (!oe_n) begin
                    lane_op[i] = LANE_READ;
                end
            end
        end
        assign wr_en[i] = (lane_op[i] == LANE_WRITE);
        assign rd_en[i] = (lane_op[i] == LANE_READ);
    end
endmodule

// File: rtl/dpr_lane_fwd.sv
module dpr_lane_fwd #(
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANE_W-1:0] stored,
    input  logic              hit_pri,
    input  logic [LANE_W-1:0] data_pri,
    input  logic              hit_sec,
    input  logic [LANE_W-1:0] data_sec,
    output logic [LANE_W-1:0] value
);
    // Same ordering as the array update: the primary port (A) overrides.
    always_comb begin
        if (hit_pri)      value = data_pri;
        else if (hit_sec) value = data_sec;
        else              value = stored;
    end
endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                         clk,
    input  logic [ADDR_W-1:0]            a_addr,
    input  logic [LANES-1:0]             a_wr,
    input  logic [LANES-1:0][LANE_W-1:0] a_data,
    input  logic [ADDR_W-1:0]            b_addr,
    input  logic [LANES-1:0]             b_wr,
    input  logic [LANES-1:0][LANE_W-1:0] b_data,
    output logic [LANES-1:0][LANE_W-1:0] a_q,
    output logic [LANES-1:0][LANE_W-1:0] b_q
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            // B first, A last: A wins a same-lane, same-address collision.
            if (b_wr[i]) mem[b_addr][i] <= b_data[i];
            if (a_wr[i]) mem[a_addr][i] <= a_data[i];
        end
    end

    assign a_q = mem[a_addr];
    assign b_q = mem[b_addr];
endmodule

// File: rtl/dpram_bytelane.sv
module dpram_bytelane
    import dpr_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned LANE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          a_addr,
    input  logic                       a_cs_n,
    input  logic                       a_oe_n,
    input  logic [NLANES-1:0]          a_we_n,
    input  logic                       a_hold_n,
    input  logic [NLANES*LANE_W-1:0]   a_wdata,
    output logic [NLANES*LANE_W-1:0]   a_rdata,
    output logic [NLANES-1:0]          a_drive,
    input  logic [ADDR_W-1:0]          b_addr,
    input  logic                       b_cs_n,
    input  logic                       b_oe_n,
    input  logic [NLANES-1:0]          b_we_n,
    input  logic                       b_hold_n,
    input  logic [NLANES*LANE_W-1:0]   b_wdata,
    output logic [NLANES*LANE_W-1:0]   b_rdata,
    output logic [NLANES-1:0]          b_drive
);
    localparam int unsigned LANES  = NLANES;
    localparam int unsigned DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic [LANES-1:0]  a_drv;
        logic [DATA_W-1:0] a_rd;
        logic [LANES-1:0]  b_drv;
        logic [DATA_W-1:0] b_rd;
    } out_s;

    out_s s_d, s_q;

    logic [LANES-1:0] a_wr, a_rd_en, b_wr, b_rd_en;
    logic [LANES-1:0][LANE_W-1:0] a_q, b_q, a_view, b_view, a_wlanes, b_wlanes;
    logic same_addr;

    assign a_wlanes  = a_wdata;
    assign b_wlanes  = b_wdata;
    assign same_addr = (a_addr == b_addr);

    dpr_port_decode #(.LANES(LANES)) u_dec_a (
        .cs_n(a_cs_n), .oe_n(a_oe_n), .we_n(a_we_n), .hold_n(a_hold_n),
        .wr_en(a_wr), .rd_en(a_rd_en)
    );

    dpr_port_decode #(.LANES(LANES)) u_dec_b (
        .cs_n(b_cs_n), .oe_n(b_oe_n), .we_n(b_we_n), .hold_n(b_hold_n),
        .wr_en(b_wr), .rd_en(b_rd_en)
    );

    dpr_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk(clk),
        .a_addr(a_addr), .a_wr(a_wr), .a_data(a_wlanes),
        .b_addr(b_addr), .b_wr(b_wr), .b_data(b_wlanes),
        .a_q(a_q), .b_q(b_q)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_fwd
        // Port A view: own write has priority, B's write only when aimed here.
        dpr_lane_fwd #(.LANE_W(LANE_W)) u_fwd_a (
            .stored(a_q[i]),
            .hit_pri(a_wr[i]),              .data_pri(a_wlanes[i]),
            .hit_sec(b_wr[i] && same_addr), .data_sec(b_wlanes[i]),
            .value(a_view[i])
        );
        // Port B view: A's write still wins when both hit the same lane.
        dpr_lane_fwd #(.LANE_W(LANE_W)) u_fwd_b (
            .stored(b_q[i]),
            .hit_pri(a_wr[i] && same_addr), .data_pri(a_wlanes[i]),
            .hit_sec(b_wr[i]),              .data_sec(b_wlanes[i]),
            .value(b_view[i])
        );
    end

    always_comb begin
        s_d = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            s_d.a_drv[i] = a_rd_en[i];
            s_d.b_drv[i] = b_rd_en[i];
            s_d.a_rd[i*LANE_W +: LANE_W] = a_rd_en[i] ? a_view[i] : '0;
            s_d.b_rd[i*LANE_W +: LANE_W] = b_rd_en[i] ? b_view[i] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign a_drive = s_q.a_drv;
    assign a_rdata = s_q.a_rd;
    assign b_drive = s_q.b_drv;
    assign b_rdata = s_q.b_rd;
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned LANE_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     a_addr,
    input logic                  a_cs_n,
    input logic                  a_oe_n,
    input logic [1:0]            a_we_n,
    input logic                  a_hold_n,
    input logic [2*LANE_W-1:0]   a_wdata,
    input logic [2*LANE_W-1:0]   a_rdata,
    input logic [1:0]            a_drive,
    input logic [ADDR_W-1:0]     b_addr,
    input logic                  b_cs_n,
    input logic                  b_oe_n,
    input logic [1:0]            b_we_n,
    input logic                  b_hold_n,
    input logic [2*LANE_W-1:0]   b_wdata,
    input logic [2*LANE_W-1:0]   b_rdata,
    input logic [1:0]            b_drive
);
    // R1
    a_desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_cs_n |=> (a_drive == 2'b00 && a_rdata == '0));

    // R1
    b_desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_cs_n |=> (b_drive == 2'b00 && b_rdata == '0));

    // R6
    a_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_cs_n && a_oe_n) |=> (a_drive == 2'b00));

    // R3
    a_lo_wr_hi_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_cs_n && !a_oe_n && a_we_n == 2'b10) |=> (a_drive == 2'b10));

    // R4
    b_hi_wr_lo_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_cs_n && !b_oe_n && b_we_n == 2'b01) |=> (b_drive == 2'b01));

    // R8
    dual_read_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_cs_n && !a_oe_n && a_we_n == 2'b11 && !b_cs_n && !b_oe_n &&
         b_we_n == 2'b11 && a_addr == b_addr) |=> (a_rdata == b_rdata));

    // R9
    a_to_b_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_cs_n && a_hold_n && a_we_n == 2'b00 && !b_cs_n && !b_oe_n &&
         b_we_n == 2'b11 && a_addr == b_addr) |=> (b_rdata == $past(a_wdata)));

    // R11
    a_idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drive == 2'b00) |-> (a_rdata == '0));
endmodule

bind dpram_bytelane dpr_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_cs_n(a_cs_n), .a_oe_n(a_oe_n), .a_we_n(a_we_n),
    .a_hold_n(a_hold_n), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_drive(a_drive),
    .b_addr(b_addr), .b_cs_n(b_cs_n), .b_oe_n(b_oe_n), .b_we_n(b_we_n),
    .b_hold_n(b_hold_n), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_drive(b_drive)
);

// File: tb/tb_dpram_bytelane.sv
module tb_dpram_bytelane;
    typedef struct packed {
        logic [10:0] addr;
        logic        cs_n;
        logic        oe_n;
        logic [1:0]  we_n;
        logic        hold_n;
        logic [15:0] wdata;
    } pin_t;

    typedef struct packed {
        pin_t        a;
        pin_t        b;
        logic [1:0]  ea_drv;
        logic [15:0] ea_rd;
        logic [1:0]  eb_drv;
        logic [15:0] eb_rd;
        logic [3:0]  req;
    } vec_t;

    // control = {cs_n, oe_n, we_n[1] upper, we_n[0] lower, hold_n}
    localparam logic [4:0] IDLE  = 5'b11111;
    localparam logic [4:0] WR2   = 5'b01001;
    localparam logic [4:0] WRLO  = 5'b00101; // write lower, read upper
    localparam logic [4:0] WRHI  = 5'b00011; // write upper, read lower
    localparam logic [4:0] RD    = 5'b00111;
    localparam logic [4:0] NOOE  = 5'b01111;
    localparam logic [4:0] DSWR  = 5'b10001; // deselected, strobes low
    localparam logic [4:0] WR2H  = 5'b01000; // write both, held
    localparam logic [4:0] WRLOH = 5'b00100; // write lower held, read upper

    function automatic pin_t mk(input logic [10:0] ad, input logic [4:0] c, input logic [15:0] wd);
        pin_t p;
        p.addr = ad; p.cs_n = c[4]; p.oe_n = c[3]; p.we_n = c[2:1];
        p.hold_n = c[0]; p.wdata = wd;
        return p;
    endfunction

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{mk(11'h010, WR2,  16'hA1B2), mk(11'h000, IDLE, 16'h0),    2'b00, 16'h0,    2'b00, 16'h0,    4'd2},  // R2
        '{mk(11'h010, RD,   16'h0),    mk(11'h010, RD,   16'h0),    2'b11, 16'hA1B2, 2'b11, 16'hA1B2, 4'd5},  // R5
        '{mk(11'h010, WRLO, 16'hFF33), mk(11'h000, IDLE, 16'h0),    2'b10, 16'hA100, 2'b00, 16'h0,    4'd3},  // R3
        '{mk(11'h010, WRHI, 16'h5C77), mk(11'h000, IDLE, 16'h0),    2'b01, 16'h0033, 2'b00, 16'h0,    4'd4},  // R4
        '{mk(11'h010, RD,   16'h0),    mk(11'h010, NOOE, 16'h0),    2'b11, 16'h5C33, 2'b00, 16'h0,    4'd6},  // R6
        '{mk(11'h010, DSWR, 16'h0000), mk(11'h010, RD,   16'h0),    2'b00, 16'h0,    2'b11, 16'h5C33, 4'd1},  // R1
        '{mk(11'h010, RD,   16'h0),    mk(11'h000, IDLE, 16'h0),    2'b11, 16'h5C33, 2'b00, 16'h0,    4'd1},  // R1
        '{mk(11'h020, WR2H, 16'h1234), mk(11'h020, WR2,  16'h4321), 2'b00, 16'h0,    2'b00, 16'h0,    4'd7},  // R7
        '{mk(11'h020, RD,   16'h0),    mk(11'h000, IDLE, 16'h0),    2'b11, 16'h4321, 2'b00, 16'h0,    4'd7},  // R7
        '{mk(11'h020, WRLOH,16'h00EE), mk(11'h000, IDLE, 16'h0),    2'b10, 16'h4300, 2'b00, 16'h0,    4'd7},  // R7
        '{mk(11'h000, IDLE, 16'h0),    mk(11'h020, RD,   16'h0),    2'b00, 16'h0,    2'b11, 16'h4321, 4'd7},  // R7
        '{mk(11'h030, WR2,  16'hBEEF), mk(11'h030, RD,   16'h0),    2'b00, 16'h0,    2'b11, 16'hBEEF, 4'd9},  // R9
        '{mk(11'h030, RD,   16'h0),    mk(11'h030, WRHI, 16'h7700), 2'b11, 16'h77EF, 2'b01, 16'h00EF, 4'd9},  // R9
        '{mk(11'h040, WR2,  16'h1111), mk(11'h040, WR2,  16'h2222), 2'b00, 16'h0,    2'b00, 16'h0,    4'd10}, // R10
        '{mk(11'h000, IDLE, 16'h0),    mk(11'h040, RD,   16'h0),    2'b00, 16'h0,    2'b11, 16'h1111, 4'd10}, // R10
        '{mk(11'h050, WRLO, 16'h00AA), mk(11'h050, WRHI, 16'hBB00), 2'b10, 16'hBB00, 2'b01, 16'h00AA, 4'd9},  // R9
        '{mk(11'h050, RD,   16'h0),    mk(11'h050, RD,   16'h0),    2'b11, 16'hBBAA, 2'b11, 16'hBBAA, 4'd8},  // R8
        '{mk(11'h000, WR2,  16'h0F0F), mk(11'h000, IDLE, 16'h0),    2'b00, 16'h0,    2'b00, 16'h0,    4'd12}, // R12
        '{mk(11'h7FF, WR2,  16'hC0DE), mk(11'h7FF, RD,   16'h0),    2'b00, 16'h0,    2'b11, 16'hC0DE, 4'd12}, // R12
        '{mk(11'h000, RD,   16'h0),    mk(11'h7FF, RD,   16'h0),    2'b11, 16'h0F0F, 2'b11, 16'hC0DE, 4'd12}  // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    pin_t        pa, pb;
    logic [15:0] a_rdata, b_rdata;
    logic [1:0]  a_drive, b_drive;
    int          n_tests = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    dpram_bytelane dut (
        .clk(clk), .rst_n(rst_n),
        .a_addr(pa.addr), .a_cs_n(pa.cs_n), .a_oe_n(pa.oe_n), .a_we_n(pa.we_n),
        .a_hold_n(pa.hold_n), .a_wdata(pa.wdata), .a_rdata(a_rdata), .a_drive(a_drive),
        .b_addr(pb.addr), .b_cs_n(pb.cs_n), .b_oe_n(pb.oe_n), .b_we_n(pb.we_n),
        .b_hold_n(pb.hold_n), .b_wdata(pb.wdata), .b_rdata(b_rdata), .b_drive(b_drive)
    );

    task automatic chk(input string what, input int req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        pa = mk(11'h0, IDLE, 16'h0);
        pb = mk(11'h0, IDLE, 16'h0);
        repeat (3) @(posedge clk);
        #2;
        // R11: reset state
        chk("reset a_drive", 11, {14'h0, a_drive}, 16'h0);
        chk("reset a_rdata", 11, a_rdata, 16'h0);
        chk("reset b_drive", 11, {14'h0, b_drive}, 16'h0);
        chk("reset b_rdata", 11, b_rdata, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pa = VECS[i].a;
            pb = VECS[i].b;
            @(posedge clk);
            #2;
            chk($sformatf("vec%0d a_drive", i), int'(VECS[i].req), {14'h0, a_drive}, {14'h0, VECS[i].ea_drv});
            chk($sformatf("vec%0d a_rdata", i), int'(VECS[i].req), a_rdata, VECS[i].ea_rd);
            chk($sformatf("vec%0d b_drive", i), int'(VECS[i].req), {14'h0, b_drive}, {14'h0, VECS[i].eb_drv});
            chk($sformatf("vec%0d b_rdata", i), int'(VECS[i].req), b_rdata, VECS[i].eb_rd);
        end

        // R5: latency - the new address shows exactly one edge later
        @(negedge clk);
        pa = mk(11'h010, RD, 16'h0);
        pb = mk(11'h000, IDLE, 16'h0);
        #1;
        chk("latency before edge", 5, a_rdata, 16'h0F0F);
        @(posedge clk);
        #2;
        chk("latency after edge", 5, a_rdata, 16'h5C33);

        // R11: reset asserted mid-read clears outputs at once
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("mid-run reset a_drive", 11, {14'h0, a_drive}, 16'h0);
        chk("mid-run reset a_rdata", 11, a_rdata, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        // R12: contents survive the output reset
        chk("read after reset", 12, a_rdata, 16'h5C33);

        @(negedge clk);
        pa = mk(11'h0, IDLE, 16'h0);
        finish_run();
    end
endmodule